// File: doc/BRIEF.md
# I2C Host Pause and Restart Sequencer

This block decides when an I2C host stops its clock to wait for software and what happens once a transfer ends. It counts the falling SCL edges of each 9-edge frame, as reported by the bit engine, and at each edge it looks at the receive-buffer-full and transmit-buffer-empty flags, the remaining byte count, the acknowledge bit received from the client and a restart-enable control. From these it raises a data-request flag that holds SCL low, or it commands the bit engine to send a Stop. It also tracks the start request used to open a transfer or to resume one with a Restart.

Software acts on the block through three single-cycle strobes: a receive-buffer read, a transmit-buffer write and a write of one to the start bit. The bit engine answers each command with a done strobe. The host controls work only while the top bit of the mode field selects a host mode. Leaving host mode returns the block to idle.

Top module: `hps_top`

## Requirements
- R1: A synchronous active-high reset leaves the block idle, with data_req = 0, start_req = 0 and bus_cmd = 2'b00 (none).
- R2: When the block is idle in host mode, a txbuf_wr or start_wr strobe sets start_req and drives bus_cmd = 2'b01 (Start) from the next cycle on. start_sent then clears both and begins a frame with the edge count at zero.
- R3: If rx_full is high at the 7th falling edge of a frame, data_req sets. Only rxbuf_rd clears it; txbuf_wr does not.
- R4: If tx_empty is high and byte_cnt is nonzero at the 8th falling edge, data_req sets. Only txbuf_wr clears it; rxbuf_rd does not. With byte_cnt = 0 this edge gives no pause.
- R5: If restart_en = 1 and either byte_cnt = 0 or ack_nack = 1 at the 9th falling edge, data_req sets and bus_cmd stays 2'b00.
- R6: If restart_en = 0 under the same end condition, bus_cmd becomes 2'b11 (Stop) at the 9th edge and holds until stop_sent. The block then returns to idle.
- R7: While paused for restart, txbuf_wr or start_wr clears data_req, sets start_req and drives bus_cmd = 2'b10 (Restart). start_sent clears start_req and bus_cmd.
- R8: While mode[2] = 0, every strobe is ignored and data_req, start_req and bus_cmd stay zero. The block is idle when host mode returns.
- R9: scl_fall strobes that arrive while data_req is set do not advance the frame's edge count.
- R10: When several pause conditions apply in one frame, the one at the earliest edge takes effect first. Later ones are evaluated at their own edges after release.
- R11: At a 9th edge without an end condition (byte_cnt nonzero and ack_nack = 0), there is no pause and no command. The next frame begins counting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Mode field; bit 2 = 1 selects host mode |
| restart_en | input | 1 | 1: pause for Restart at transfer end; 0: send Stop |
| scl_fall | input | 1 | One-cycle strobe per falling SCL edge from the bit engine |
| rx_full | input | 1 | Receive buffer holds unread data |
| tx_empty | input | 1 | Transmit buffer is empty |
| byte_cnt | input | CNT_W | Bytes remaining in the transfer |
| ack_nack | input | 1 | Acknowledge received from the client (1 = not acknowledged) |
| rxbuf_rd | input | 1 | Strobe: software read the receive buffer |
| txbuf_wr | input | 1 | Strobe: software wrote the transmit buffer |
| start_wr | input | 1 | Strobe: software wrote one to the start bit |
| start_sent | input | 1 | Strobe: bit engine finished a Start or Restart |
| stop_sent | input | 1 | Strobe: bit engine finished a Stop |
| data_req | output | 1 | Pause flag; SCL is held low while set |
| start_req | output | 1 | Start bit: a Start or Restart is pending |
| bus_cmd | output | 2 | Bit-engine command: 00 none, 01 Start, 10 Restart, 11 Stop |

## Verification
The assertions check on every cycle that the edge count stays frozen while SCL is held and that it never goes past eight. They also check that start_req only rises after a software strobe, that a pause and a start request are never active together, that a Stop command persists until it is acknowledged, and that leaving host mode clears every output. Only the bench's scenarios can show which edge a given flag combination triggers on, which strobe releases which pause, the ordering when the 7th and 8th edge conditions both hold, and the choice between Restart and Stop at the end of a frame. These are compared with a reference model driven by random flags and counts.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int unsigned EDGE_W   = 4;
    localparam int unsigned RX_EDGE  = 7;
    localparam int unsigned TX_EDGE  = 8;
    localparam int unsigned ACK_EDGE = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_HOLD_RX,
        ST_HOLD_TX,
        ST_HOLD_RS,
        ST_RESTART,
        ST_STOP
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_START   = 2'b01,
        CMD_RESTART = 2'b10,
        CMD_STOP    = 2'b11
    } bus_cmd_t;

    typedef struct packed {
        logic hold_rx;
        logic hold_tx;
        logic frame_end;
        logic end_xfer;
    } edge_verdict_t;

    function automatic logic mode_is_host(input logic [2:0] m);
        return m[2];
    endfunction

    function automatic logic state_holds(input seq_state_t s);
        return (s == ST_HOLD_RX) || (s == ST_HOLD_TX) || (s == ST_HOLD_RS);
    endfunction

    function automatic bus_cmd_t state_cmd(input seq_state_t s);
        case (s)
            ST_START:   return CMD_START;
            ST_RESTART: return CMD_RESTART;
            ST_STOP:    return CMD_STOP;
            default:    return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hps_edge_ctr.sv
module hps_edge_ctr
    import hps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [EDGE_W-1:0] cnt,
    output logic [EDGE_W-1:0] nxt
);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign nxt = cnt + 1'b1;

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= EDGE_W'(TX_EDGE));

endmodule

// File: rtl/hps_edge_eval.sv
module hps_edge_eval
    import hps_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [EDGE_W-1:0] edge_no,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              ack_nack,
    output edge_verdict_t     verdict
);

    logic cnt_zero;
    assign cnt_zero = (byte_cnt == '0);

    always_comb begin
        verdict.hold_rx   = (edge_no == EDGE_W'(RX_EDGE)) && rx_full;
        verdict.hold_tx   = (edge_no == EDGE_W'(TX_EDGE)) && tx_empty && !cnt_zero;
        verdict.frame_end = (edge_no == EDGE_W'(ACK_EDGE));
        verdict.end_xfer  = verdict.frame_end && (cnt_zero || ack_nack);
    end

endmodule

// File: rtl/hps_fsm.sv
module hps_fsm
    import hps_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host,
    input  logic          restart_en,
    input  logic          scl_fall,
    input  edge_verdict_t verdict,
    input  logic          rxbuf_rd,
    input  logic          txbuf_wr,
    input  logic          start_wr,
    input  logic          start_sent,
    input  logic          stop_sent,
    output seq_state_t    state,
    output logic          ctr_clr,
    output logic          ctr_inc
);

    seq_state_t nxt_state;

    always_comb begin
        nxt_state = state;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        if (!host) begin
            nxt_state = ST_IDLE;
            ctr_clr   = 1'b1;
        end else begin
            case (state)
                ST_IDLE:
                    if (txbuf_wr || start_wr) nxt_state = ST_START;
                ST_START, ST_RESTART:
                    if (start_sent) begin
                        nxt_state = ST_RUN;
                        ctr_clr   = 1'b1;
                    end
                ST_RUN:
                    if (scl_fall) begin
                        ctr_inc = 1'b1;
                        if (verdict.hold_rx)      nxt_state = ST_HOLD_RX;
                        else if (verdict.hold_tx) nxt_state = ST_HOLD_TX;
                        else if (verdict.frame_end) begin
                            ctr_clr = 1'b1;
                            if (verdict.end_xfer)
                                nxt_state = restart_en ? ST_HOLD_RS : ST_STOP;
                        end
                    end
                ST_HOLD_RX:
                    if (rxbuf_rd) nxt_state = ST_RUN;
                ST_HOLD_TX:
                    if (txbuf_wr) nxt_state = ST_RUN;
                ST_HOLD_RS:
                    if (txbuf_wr || start_wr) nxt_state = ST_RESTART;
                ST_STOP:
                    if (stop_sent) nxt_state = ST_IDLE;
                default:
                    nxt_state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt_state;
    end

    // R3
    rx_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD_RX) && host && !rxbuf_rd |=> state == ST_HOLD_RX);

endmodule

// File: rtl/hps_top.sv
module hps_top
    import hps_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             restart_en,
    input  logic             scl_fall,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             ack_nack,
    input  logic             rxbuf_rd,
    input  logic             txbuf_wr,
    input  logic             start_wr,
    input  logic             start_sent,
    input  logic             stop_sent,
    output logic             data_req,
    output logic             start_req,
    output logic [1:0]       bus_cmd
);

    logic              host;
    logic              ctr_clr;
    logic              ctr_inc;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nxt;
    edge_verdict_t     verdict;
    seq_state_t        state;

    assign host = mode_is_host(mode);

    hps_edge_ctr u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (ctr_clr),
        .inc (ctr_inc),
        .cnt (edge_cnt),
        .nxt (edge_nxt)
    );

    hps_edge_eval #(.CNT_W(CNT_W)) u_eval (
        .edge_no  (edge_nxt),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .byte_cnt (byte_cnt),
        .ack_nack (ack_nack),
        .verdict  (verdict)
    );

    hps_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .host       (host),
        .restart_en (restart_en),
        .scl_fall   (scl_fall),
        .verdict    (verdict),
        .rxbuf_rd   (rxbuf_rd),
        .txbuf_wr   (txbuf_wr),
        .start_wr   (start_wr),
        .start_sent (start_sent),
        .stop_sent  (stop_sent),
        .state      (state),
        .ctr_clr    (ctr_clr),
        .ctr_inc    (ctr_inc)
    );

    assign data_req  = state_holds(state);
    assign start_req = (state == ST_START) || (state == ST_RESTART);
    assign bus_cmd   = state_cmd(state);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !data_req && !start_req && (bus_cmd == 2'b00));

    // R9
    paused_edges_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        data_req && host |=> $stable(edge_cnt));

    // R2
    start_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_req) |-> $past(txbuf_wr || start_wr));

    // R7
    pause_xor_start_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_req, start_req}));

    // R6
    stop_held_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'b11) && !stop_sent && host |=> bus_cmd == 2'b11);

    // R8
    client_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host |=> !data_req && !start_req && (bus_cmd == 2'b00));

endmodule

// File: tb/sim_hps_top.sv
`timescale 1ns/1ps
module sim_hps_top;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       mode = 3'b100;
    logic             restart_en = 1'b0;
    logic             scl_fall = 1'b0;
    logic             rx_full = 1'b0;
    logic             tx_empty = 1'b0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic             ack_nack = 1'b0;
    logic             rxbuf_rd = 1'b0;
    logic             txbuf_wr = 1'b0;
    logic             start_wr = 1'b0;
    logic             start_sent = 1'b0;
    logic             stop_sent = 1'b0;
    logic             data_req;
    logic             start_req;
    logic [1:0]       bus_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hps_top #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .restart_en(restart_en),
        .scl_fall(scl_fall), .rx_full(rx_full), .tx_empty(tx_empty),
        .byte_cnt(byte_cnt), .ack_nack(ack_nack), .rxbuf_rd(rxbuf_rd),
        .txbuf_wr(txbuf_wr), .start_wr(start_wr), .start_sent(start_sent),
        .stop_sent(stop_sent), .data_req(data_req), .start_req(start_req),
        .bus_cmd(bus_cmd)
    );

    // Reference model: 0 idle,1 start,2 run,3 hold rx,4 hold tx,5 hold rs,6 restart,7 stop
    int m_st = 0;
    int m_cnt = 0;

    always @(posedge clk) begin
        if (rst || !mode[2]) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (txbuf_wr || start_wr) m_st = 1;
                1, 6: if (start_sent) begin m_st = 2; m_cnt = 0; end
                2: if (scl_fall) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == 7 && rx_full) m_st = 3;
                    else if (m_cnt == 8 && tx_empty && byte_cnt != 0) m_st = 4;
                    else if (m_cnt == 9) begin
                        m_cnt = 0;
                        if (byte_cnt == 0 || ack_nack) m_st = restart_en ? 5 : 7;
                    end
                end
                3: if (rxbuf_rd) m_st = 2;
                4: if (txbuf_wr) m_st = 2;
                5: if (txbuf_wr || start_wr) m_st = 6;
                default: if (stop_sent) m_st = 0;
            endcase
        end
    end

    function automatic logic [3:0] model_out(input int st);
        logic dr, sr;
        logic [1:0] c;
        dr = (st == 3 || st == 4 || st == 5);
        sr = (st == 1 || st == 6);
        c  = (st == 1) ? 2'b01 : (st == 6) ? 2'b10 : (st == 7) ? 2'b11 : 2'b00;
        return {dr, sr, c};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {data_req, start_req, bus_cmd};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {data_req,start_req,bus_cmd} got %b expected %b at %0t",
                     req, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) begin
            scl_fall = 1'b1; cyc(); scl_fall = 1'b0;
        end
    endtask

    task automatic strobe_rd();    rxbuf_rd = 1'b1;   cyc(); rxbuf_rd = 1'b0;   endtask
    task automatic strobe_wr();    txbuf_wr = 1'b1;   cyc(); txbuf_wr = 1'b0;   endtask
    task automatic strobe_start(); start_wr = 1'b1;   cyc(); start_wr = 1'b0;   endtask
    task automatic strobe_sent();  start_sent = 1'b1; cyc(); start_sent = 1'b0; endtask
    task automatic strobe_stop();  stop_sent = 1'b1;  cyc(); stop_sent = 1'b0;  endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7041));
        cyc(); cyc();
        rst = 1'b0;
        check("R1 reset", 4'b0000);

        // R2 start from idle
        strobe_start();
        check("R2 start request", 4'b0101);
        cyc();
        check("R2 start held", 4'b0101);
        strobe_sent();
        check("R2 start cleared", 4'b0000);

        // R10 rx and tx both pending, R9 spurious edges
        rx_full = 1; tx_empty = 1; byte_cnt = 3; ack_nack = 0; restart_en = 0;
        falls(6);
        check("R3 no pause before edge 7", 4'b0000);
        falls(1);
        check("R10 rx pause at edge 7", 4'b1000);
        falls(2);
        strobe_wr();
        check("R3 txbuf_wr does not release", 4'b1000);
        rx_full = 0;
        strobe_rd();
        check("R3 rxbuf_rd releases", 4'b0000);
        falls(1);
        check("R9 next edge is 8th, tx pause", 4'b1000);
        strobe_rd();
        check("R4 rxbuf_rd does not release", 4'b1000);
        strobe_wr();
        check("R4 txbuf_wr releases", 4'b0000);
        falls(1);
        check("R11 edge 9 without end condition", 4'b0000);

        // new frame, byte_cnt zero, restart enabled
        tx_empty = 1; byte_cnt = 0; restart_en = 1;
        falls(8);
        check("R4 no pause when byte_cnt zero", 4'b0000);
        falls(1);
        check("R5 restart pause at edge 9", 4'b1000);
        cyc();
        check("R5 pause held", 4'b1000);
        strobe_start();
        check("R7 restart issued", 4'b0110);
        strobe_sent();
        check("R7 restart complete", 4'b0000);

        // nack with restart enabled
        byte_cnt = 5; ack_nack = 1; tx_empty = 0;
        falls(9);
        check("R5 nack pause at edge 9", 4'b1000);
        strobe_wr();
        check("R7 txbuf_wr restarts", 4'b0110);
        strobe_sent();

        // stop path
        restart_en = 0; ack_nack = 1;
        falls(9);
        check("R6 stop command", 4'b0011);
        cyc(); cyc();
        check("R6 stop held", 4'b0011);
        strobe_stop();
        check("R6 idle after stop", 4'b0000);
        strobe_wr();
        check("R2 txbuf_wr starts", 4'b0101);

        // client mode
        mode = 3'b001;
        cyc();
        check("R8 host mode left", 4'b0000);
        strobe_start();
        strobe_wr();
        check("R8 strobes ignored", 4'b0000);
        mode = 3'b110;
        cyc();
        check("R8 idle on return", 4'b0000);

        // random phase against reference model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 64 == 0)
                mode = ($urandom % 5 == 0) ? 3'($urandom % 4) : 3'(4 + $urandom % 4);
            restart_en = 1'($urandom % 2);
            rx_full    = 1'($urandom % 2);
            tx_empty   = 1'($urandom % 2);
            byte_cnt   = CNT_W'($urandom % 4);
            ack_nack   = ($urandom % 4 == 0);
            scl_fall   = (m_st == 2) ? 1'($urandom % 2) : ($urandom % 8 == 0);
            rxbuf_rd   = ($urandom % 5 == 0);
            txbuf_wr   = ($urandom % 6 == 0);
            start_wr   = ($urandom % 7 == 0);
            start_sent = ($urandom % 3 == 0);
            stop_sent  = ($urandom % 3 == 0);
            cyc();
            check("ALL model", model_out(m_st));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule